// File: doc/BRIEF.md
# Pretrigger Capture Controller

This block runs one acquisition into a circular sample buffer. A start pulse latches the run settings, clears the write address, and makes the block busy. From then on, every valid sample is written at the current ring address, and the address advances. The ring length equals the total depth.

Two trigger hit inputs are each gated by their own enable bit. A mode bit then combines them with OR or with AND. A trigger is only taken once the programmed pretrigger amount has been stored since start. The address of the first qualifying sample is latched as the trigger position. Readout can begin at the oldest pretrigger sample, which sits a pretrigger distance behind that position.

After the trigger, the block writes the remaining post-trigger samples, stops, and pulses done. Depths are given in blocks of 512 samples. Total depth runs from 4 to 131072 blocks (2k to 64M samples), and the pretrigger depth must be strictly smaller than the total.

Top module: `pretrig_capture_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, wr_en_o and trig_vld_o are 0 and wr_addr_o is 0.
- R2: A start pulse latches total_blks_i, pre_blks_i, trig_en_i and trig_and_i (depths are counted in units of 512 samples). On the next cycle busy_o is 1 and wr_addr_o is 0. While busy, wr_en_o equals sample_vld_i in the same cycle.
- R3: Hit A counts only when trig_en_i bit 0 is 1. Hit B counts only when trig_en_i bit 1 is 1.
- R4: With trig_and_i = 0 the enabled hits are ORed; with trig_and_i = 1 they are ANDed. With a single enabled source, either mode follows that source alone. With no source enabled, the first eligible sample triggers.
- R5: Hits are ignored on the first pre samples written after start (pre = 512 × pre_blks). With pre = 0, the first written sample is eligible.
- R6: The write address increments by one per written sample and wraps from total − 1 to 0 (total = 512 × total_blks).
- R7: trig_addr_o holds the address of the first sample that is eligible, written and triggering. trig_vld_o rises one cycle after that write, and both hold until the next start.
- R8: Exactly total − pre samples are written from the trigger sample onward. done_o is 1 for one cycle, in the cycle after the last such write. busy_o is 0 in that same cycle, and later samples give no wr_en_o.
- R9: A start pulse while busy aborts the run and restarts it with cleared address, counters and trigger flag. rst returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or restart pulse |
| sample_vld_i | input | 1 | A sample is present this cycle |
| hit_a_i | input | 1 | Trigger hit from source A |
| hit_b_i | input | 1 | Trigger hit from source B |
| trig_en_i | input | 2 | Source enables: bit 0 for A, bit 1 for B |
| trig_and_i | input | 1 | Combine mode: 0 for OR, 1 for AND |
| total_blks_i | input | ADDR_W-8 | Total depth in 512-sample blocks |
| pre_blks_i | input | ADDR_W-8 | Pretrigger depth in 512-sample blocks |
| wr_addr_o | output | ADDR_W | Buffer write address |
| wr_en_o | output | 1 | Buffer write enable |
| busy_o | output | 1 | Acquisition in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trig_addr_o | output | ADDR_W | Address of the trigger sample |
| trig_vld_o | output | 1 | Trigger position is valid |

## Verification
wr_en_o follows sample_vld_i combinationally, so the bench reads it and wr_addr_o in the same cycle the sample is driven. busy_o, trig_vld_o, trig_addr_o and done_o come from registers, so each is read one edge after the causing input: busy one cycle after start, the trigger flag one cycle after the qualifying write, and done one cycle after the last post-trigger write. Inputs change just after a rising edge and every output is read at the falling edge, so each check lands on the cycle in which its result is due.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;

    localparam int BLK_SHIFT = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_ARMED,
        ST_POST
    } cap_state_e;

    typedef struct packed {
        logic [1:0] en;
        logic       and_mode;
    } trig_cfg_t;

    function automatic logic combine_hits(input trig_cfg_t cfg, input logic [1:0] hits);
        logic any_hit;
        logic all_hit;
        any_hit = |(hits & cfg.en);
        all_hit = &(hits | ~cfg.en);
        if (cfg.en == 2'b00)
            return 1'b1;
        return cfg.and_mode ? all_hit : any_hit;
    endfunction

endpackage

// File: rtl/pretrig_trig_combine.sv
module pretrig_trig_combine
    import pretrig_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  trig_cfg_t        cfg_i,
    input  logic [NSRC-1:0]  hit_i,
    output logic             fire_o
);
    logic [1:0] hits;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_src
            if (g < NSRC) begin : g_used
                assign hits[g] = hit_i[g];
            end else begin : g_tie
                assign hits[g] = 1'b0;
            end
        end
    endgenerate

    assign fire_o = combine_hits(cfg_i, hits);
endmodule

// File: rtl/pretrig_addr_ring.sv
module pretrig_addr_ring #(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] last_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            addr_q <= '0;
        else if (adv_i)
            addr_q <= (addr_q == last_i) ? '0 : addr_q + 1'b1;
    end

    assign addr_o = addr_q;

    // R6
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !clear_i && addr_q == last_i) |=> (addr_q == '0));

    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !clear_i && addr_q != last_i) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/pretrig_seq_fsm.sv
module pretrig_seq_fsm
    import pretrig_pkg::*;
#(
    parameter int ADDR_W = 26,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  pre_now_i,
    input  logic [CNT_W-1:0]  pre_q_i,
    input  logic [CNT_W-1:0]  post_q_i,
    input  logic              wr_i,
    input  logic              fire_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] trig_addr_o,
    output logic              trig_vld_o
);
    cap_state_e        state_q;
    logic [CNT_W-1:0]  fill_cnt_q;
    logic [CNT_W-1:0]  post_cnt_q;
    logic [ADDR_W-1:0] trig_addr_q;
    logic              trig_vld_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            fill_cnt_q  <= '0;
            post_cnt_q  <= '0;
            trig_addr_q <= '0;
            trig_vld_q  <= 1'b0;
            done_q      <= 1'b0;
        end else if (start_i) begin
            state_q     <= (pre_now_i == '0) ? ST_ARMED : ST_FILL;
            fill_cnt_q  <= '0;
            post_cnt_q  <= '0;
            trig_addr_q <= '0;
            trig_vld_q  <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_FILL: begin
                    if (wr_i) begin
                        fill_cnt_q <= fill_cnt_q + 1'b1;
                        if (fill_cnt_q + 1'b1 == pre_q_i)
                            state_q <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (wr_i && fire_i) begin
                        trig_addr_q <= wr_addr_i;
                        trig_vld_q  <= 1'b1;
                        post_cnt_q  <= {{(CNT_W-1){1'b0}}, 1'b1};
                        if (post_q_i == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_POST;
                        end
                    end
                end
                ST_POST: begin
                    if (wr_i) begin
                        post_cnt_q <= post_cnt_q + 1'b1;
                        if (post_cnt_q + 1'b1 == post_q_i) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign trig_addr_o = trig_addr_q;
    assign trig_vld_o  = trig_vld_q;

    // R5
    armed_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED) |-> (fill_cnt_q == pre_q_i));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7
    trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_vld_q && !start_i) |=> (trig_vld_q && $stable(trig_addr_q)));

    // R8
    post_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POST) |-> (post_cnt_q < post_q_i));
endmodule

// File: rtl/pretrig_capture_ctrl.sv
module pretrig_capture_ctrl
    import pretrig_pkg::*;
#(
    parameter int ADDR_W = 26,
    localparam int CNT_W = ADDR_W + 1,
    localparam int BLK_W = CNT_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sample_vld_i,
    input  logic              hit_a_i,
    input  logic              hit_b_i,
    input  logic [1:0]        trig_en_i,
    input  logic              trig_and_i,
    input  logic [BLK_W-1:0]  total_blks_i,
    input  logic [BLK_W-1:0]  pre_blks_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] trig_addr_o,
    output logic              trig_vld_o
);
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  pre_q;
    trig_cfg_t         tcfg_q;
    logic [CNT_W-1:0]  post_len;
    logic [CNT_W-1:0]  pre_now;
    logic [ADDR_W-1:0] ring_last;
    logic              fire;
    logic              wr;
    logic              busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q <= '0;
            pre_q   <= '0;
            tcfg_q  <= '0;
        end else if (start_i) begin
            total_q <= {total_blks_i, {BLK_SHIFT{1'b0}}};
            pre_q   <= pre_now;
            tcfg_q  <= '{en: trig_en_i, and_mode: trig_and_i};
        end
    end

    assign pre_now   = {pre_blks_i, {BLK_SHIFT{1'b0}}};
    assign post_len  = total_q - pre_q;
    assign ring_last = total_q[ADDR_W-1:0] - 1'b1;
    assign wr        = sample_vld_i && busy;

    pretrig_trig_combine #(.NSRC(2)) comb_i (
        .cfg_i  (tcfg_q),
        .hit_i  ({hit_b_i, hit_a_i}),
        .fire_o (fire)
    );

    pretrig_addr_ring #(.ADDR_W(ADDR_W)) ring_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_i),
        .adv_i   (wr),
        .last_i  (ring_last),
        .addr_o  (wr_addr_o)
    );

    pretrig_seq_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .pre_now_i   (pre_now),
        .pre_q_i     (pre_q),
        .post_q_i    (post_len),
        .wr_i        (wr),
        .fire_i      (fire),
        .wr_addr_i   (wr_addr_o),
        .busy_o      (busy),
        .done_o      (done_o),
        .trig_addr_o (trig_addr_o),
        .trig_vld_o  (trig_vld_o)
    );

    assign busy_o  = busy;
    assign wr_en_o = wr;

    // R8
    no_write_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !wr_en_o);

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (busy_o && wr_addr_o == '0 && !trig_vld_o));
endmodule

// File: tb/pretrig_capture_ctrl_tb.sv
module pretrig_capture_ctrl_tb_top;
    localparam int ADDR_W = 26;
    localparam int BLK_W  = ADDR_W + 1 - 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0, vld = 1'b0, ha = 1'b0, hb = 1'b0;
    logic [1:0]        en = 2'b00;
    logic              andm = 1'b0;
    logic [BLK_W-1:0]  tot_blks = '0, pre_blks = '0;
    logic [ADDR_W-1:0] wr_addr_o, trig_addr_o;
    logic              wr_en_o, busy_o, done_o, trig_vld_o;

    int n_chk = 0;
    int n_fail = 0;
    int wr_count = 0;
    bit finished = 1'b0;

    // {en[1:0], and_mode, hit_a, hit_b, expected_fire}
    localparam logic [5:0] VEC [0:11] = '{
        6'b000001, 6'b010101, 6'b010010, 6'b100011,
        6'b100100, 6'b110101, 6'b111100, 6'b111111,
        6'b011101, 6'b101011, 6'b101100, 6'b110000
    };

    always #2 clk = ~clk;

    pretrig_capture_ctrl #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .sample_vld_i(vld),
        .hit_a_i(ha), .hit_b_i(hb), .trig_en_i(en), .trig_and_i(andm),
        .total_blks_i(tot_blks), .pre_blks_i(pre_blks),
        .wr_addr_o(wr_addr_o), .wr_en_o(wr_en_o), .busy_o(busy_o),
        .done_o(done_o), .trig_addr_o(trig_addr_o), .trig_vld_o(trig_vld_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic v, input logic a, input logic b);
        @(posedge clk);
        #1;
        start = st; vld = v; ha = a; hb = b;
        @(negedge clk);
        if (wr_en_o) wr_count++;
    endtask

    task automatic setup(input int tb, input int pb, input logic [1:0] e, input logic am);
        tot_blks = BLK_W'(tb);
        pre_blks = BLK_W'(pb);
        en = e;
        andm = am;
        step(1'b1, 1'b0, 1'b0, 1'b0);
        wr_count = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [5:0] vec;
        // R1 reset state
        repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        step(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 wr_en", wr_en_o, 0);
        chk("R1 trig_vld", trig_vld_o, 0);
        chk("R1 wr_addr", wr_addr_o, 0);

        // R3 R4 R5 trigger combination table; each new start aborts the last run (R9)
        for (int v = 0; v < 12; v++) begin
            vec = VEC[v];
            setup(4, 1, vec[5:4], vec[3]);
            for (int k = 0; k < 512; k++) step(1'b0, 1'b1, 1'b1, 1'b1);
            step(1'b0, 1'b1, vec[2], vec[1]);
            chk($sformatf("R5 hold-off vec%0d", v), trig_vld_o, 0);
            chk($sformatf("R6 addr vec%0d", v), wr_addr_o, 512);
            step(1'b0, 1'b0, 1'b0, 1'b0);
            chk($sformatf("R4 fire vec%0d", v), trig_vld_o, vec[0]);
            if (vec[0]) chk($sformatf("R7 trig_addr vec%0d", v), trig_addr_o, 512);
        end

        // R6 R7 R8 full run with wrap, OR mode on A only
        setup(4, 1, 2'b01, 1'b0);
        for (int i = 0; i < 2236; i++) begin
            if (i % 100 == 50) step(1'b0, 1'b0, 1'b1, 1'b1);
            step(1'b0, 1'b1, (i == 700), 1'b0);
            if (i == 0) begin
                chk("R2 busy after start", busy_o, 1);
                chk("R2 wr_en follows vld", wr_en_o, 1);
                chk("R2 addr zero", wr_addr_o, 0);
            end
            if (i == 2047) chk("R6 last addr", wr_addr_o, 2047);
            if (i == 2048) chk("R6 wrap", wr_addr_o, 0);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 done pulse", done_o, 1);
        chk("R8 busy low", busy_o, 0);
        chk("R8 write count", wr_count, 2236);
        chk("R7 trig_addr", trig_addr_o, 700);
        chk("R7 trig_vld", trig_vld_o, 1);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R8 done one cycle", done_o, 0);
        chk("R8 no write after done", wr_en_o, 0);
        chk("R7 trig held", trig_addr_o, 700);

        // R5 R4 zero pretrigger, no source enabled
        setup(4, 0, 2'b00, 1'b0);
        for (int i = 0; i < 2048; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 pre zero trig_addr", trig_addr_o, 0);
        chk("R8 done pre zero", done_o, 1);
        chk("R8 count pre zero", wr_count, 2048);

        // R5 R8 maximum pretrigger, AND mode with only B enabled
        setup(4, 3, 2'b10, 1'b1);
        for (int i = 0; i < 2048; i++) begin
            step(1'b0, 1'b1, 1'b0, 1'b1);
            if (i == 1536) chk("R5 no trig before fill", trig_vld_o, 0);
            if (i == 2047) chk("R8 not done early", done_o, 0);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 trig_addr max pre", trig_addr_o, 1536);
        chk("R8 done max pre", done_o, 1);

        // R9 abort by start while busy, then reset mid-run
        setup(4, 1, 2'b00, 1'b0);
        for (int i = 0; i < 600; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 triggered before abort", trig_vld_o, 1);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 busy after restart", busy_o, 1);
        chk("R9 trig cleared", trig_vld_o, 0);
        chk("R9 addr cleared", wr_addr_o, 0);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 reset idle", busy_o, 0);
        chk("R9 reset no write", wr_en_o, 0);
        chk("R9 reset addr", wr_addr_o, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule